// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital side of a 16-bit voltage-output converter. A host drives a parallel word, an active-low select, a read/write line and a load strobe. The block stages the word in an input register and moves it into the DAC register. The DAC register is presented as a code for a downstream converter model. Because the update is split into two steps, several devices that share one load strobe can all switch their outputs on the same edge. The host can also read the staged word back before committing it.

Host controls arrive asynchronously. They pass through two-flop synchronizers into the system clock domain, and edges are found on the synchronized copies. Three other ways to change the registers are provided. A transparent mode writes the bus straight through both registers. A level-sensitive reset forces both registers to zero code or to half-scale. A select pin picks the reset value, and that pin is honoured live for as long as reset is held. The bus is split into input, output and output-enable pins, so it needs no tri-state modelling. All control pins are plain levels; there is no stream handshake.

Top module: `dbuf_dac_if`

## Requirements
- R1: With `rw` low (0 = write), a low-to-high transition of `cs_n` captures `bus_din` into the input register. `dac_code` does not change.
- R2: A low-to-high transition of `ldac` copies the input register into the DAC register, and so onto `dac_code`.
- R3: While `cs_n` is low, `rw` is low and `ldac` is high, every clock writes `bus_din` into both registers, so `dac_code` follows the bus.
- R4: While `cs_n` is low and `rw` is high (1 = read), `bus_oe` is 1 and `bus_dout` carries the input register.
- R5: While `cs_n` is high, `bus_oe` is 0.
- R6: While `rst_n` is low, `dac_code` equals 16'h8000 if `rst_mid` is 1 and 16'h0000 if it is 0, with no clock edge needed. The input register is also forced to the same value, which can be read back after release.
- R7: A change of `rst_mid` while `rst_n` is low moves `dac_code` to the newly selected value at once.
- R8: Reset wins over every write and load. An `ldac` rising edge seen during reset is ignored, and after release `dac_code` keeps the reset value until the next load.
- R9: Control inputs pass two synchronizer stages. A change of `ldac` made between clock edges shows on `dac_code` after the third rising clock edge, and not after the second.
- R10: `dac_code` changes only through a load, transparent mode or reset. A write followed by a readback leaves it untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for synchronizers and registers |
| rst_n | input | 1 | Asynchronous, level-sensitive reset, active low |
| rst_mid | input | 1 | Reset value select: 1 = half-scale 16'h8000, 0 = zero 16'h0000 |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read input register, 0 = write it |
| ldac | input | 1 | Load strobe; rising edge commits input register |
| bus_din | input | 16 | Data bus, host-to-block half |
| bus_dout | output | 16 | Data bus, block-to-host half (readback word) |
| bus_oe | output | 1 | 1 when the block drives the bus |
| dac_code | output | 16 | DAC register, bit 15 is MSB, to the converter model |

## Verification
The hardest case to reach is a change of the reset select while reset is held, followed by a load pulse inside the same reset window. The bench drops `rst_n` between clock edges and toggles `rst_mid` while the clock is still running. It then pulses `ldac` and samples `dac_code` a nanosecond after each change. After release, a readback confirms that the value chosen last reached the input register. Random sequences of writes, loads, readbacks and transparent bursts then run from a fixed seed against a two-register model kept in the bench.

// File: rtl/dbuf_dac_pkg.sv
package dbuf_dac_pkg;
  // Order of host control bits inside the synchronizer vector.
  typedef struct packed {
    logic sel_n;
    logic rd;
    logic ld;
  } dac_ctl_t;

  localparam int unsigned CTL_W = $bits(dac_ctl_t);
  localparam dac_ctl_t    CTL_IDLE = '{sel_n: 1'b1, rd: 1'b1, ld: 1'b1};
endpackage

// File: rtl/dac_sync_2ff.sv
module dac_sync_2ff #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= INIT;
      q      <= INIT;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dac_reg_pair.sv
module dac_reg_pair #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [DW-1:0] rst_val,
  input  logic          sel_n_s,
  input  logic          rd_s,
  input  logic          ld_s,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] dac_q,
  output logic          sel_rise,
  output logic          ld_rise,
  output logic          xpar
);
  logic sel_prev, ld_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 1'b1;
      ld_prev  <= 1'b1;
    end else begin
      sel_prev <= sel_n_s;
      ld_prev  <= ld_s;
    end
  end

  assign sel_rise = sel_n_s & ~sel_prev;
  assign ld_rise  = ld_s & ~ld_prev;
  assign xpar     = ~sel_n_s & ~rd_s & ld_s;

  // Registers reload the reset value on every clock while reset holds,
  // so the value chosen last before release is the one kept.
  always_ff @(posedge clk) begin
    if (hold) begin
      in_q  <= rst_val;
      dac_q <= rst_val;
    end else if (xpar) begin
      in_q  <= din;
      dac_q <= din;
    end else begin
      if (sel_rise && !rd_s) in_q <= din;
      if (ld_rise)           dac_q <= in_q;
    end
  end
endmodule

// File: rtl/dbuf_dac_if.sv
module dbuf_dac_if
  import dbuf_dac_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_mid,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          ldac,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic [DW-1:0] dac_code
);
  localparam logic [DW-1:0] CODE_MID  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] CODE_ZERO = '0;

  dac_ctl_t      ctl_s;
  logic [0:0]    rel_s;
  logic          hold_w;
  logic [DW-1:0] rst_val;
  logic [DW-1:0] in_q_w, dac_q_w;
  logic          sel_rise_w, ld_rise_w, xpar_w;

  dac_sync_2ff #(.W(CTL_W), .INIT(CTL_IDLE)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, rw, ldac}),
    .q     (ctl_s)
  );

  // Reset release is synchronized; assertion acts at once via async clear.
  dac_sync_2ff #(.W(1), .INIT(1'b0)) u_rel_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rel_s)
  );

  assign hold_w  = ~rel_s[0];
  assign rst_val = rst_mid ? CODE_MID : CODE_ZERO;

  dac_reg_pair #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold_w),
    .rst_val  (rst_val),
    .sel_n_s  (ctl_s.sel_n),
    .rd_s     (ctl_s.rd),
    .ld_s     (ctl_s.ld),
    .din      (bus_din),
    .in_q     (in_q_w),
    .dac_q    (dac_q_w),
    .sel_rise (sel_rise_w),
    .ld_rise  (ld_rise_w),
    .xpar     (xpar_w)
  );

  assign dac_code = (hold_w || !rst_n) ? rst_val : dac_q_w;
  assign bus_dout = (hold_w || !rst_n) ? rst_val : in_q_w;
  assign bus_oe   = ~hold_w & ~ctl_s.sel_n & ctl_s.rd;
endmodule

// File: rtl/dbuf_dac_chk.sv
module dbuf_dac_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_mid,
  input logic          cs_n,
  input logic          rw,
  input logic [DW-1:0] bus_din,
  input logic          bus_oe,
  input logic [DW-1:0] dac_code,
  input logic          hold,
  input logic          rd_s,
  input logic          sel_rise,
  input logic          ld_rise,
  input logic          xpar,
  input logic [DW-1:0] in_q
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  assert_write_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && !rd_s && !xpar && !hold) |=> (in_q == $past(bus_din)));

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && !xpar && !hold) |=> (dac_code == $past(in_q)));

  assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xpar && !hold) |=> (dac_code == $past(bus_din)));

  assert_oe_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!$past(cs_n, 2) && $past(rw, 2)));

  assert_code_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !ld_rise && !xpar) |=> $stable(dac_code));

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_reset_value_R6: assert (dac_code == (rst_mid ? MID : '0));
    end
  end
endmodule

bind dbuf_dac_if dbuf_dac_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_mid  (rst_mid),
  .cs_n     (cs_n),
  .rw       (rw),
  .bus_din  (bus_din),
  .bus_oe   (bus_oe),
  .dac_code (dac_code),
  .hold     (hold_w),
  .rd_s     (ctl_s.rd),
  .sel_rise (sel_rise_w),
  .ld_rise  (ld_rise_w),
  .xpar     (xpar_w),
  .in_q     (in_q_w)
);

// File: tb/tb_dbuf_dac_if.sv
module tb_dbuf_dac_if;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n, rst_mid, cs_n, rw, ldac;
  logic [DW-1:0] bus_din, bus_dout, dac_code;
  logic          bus_oe;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m_in, m_dac;
  int unsigned seed_dummy;

  always #10 clk = ~clk;

  dbuf_dac_if #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rst_mid(rst_mid), .cs_n(cs_n), .rw(rw),
    .ldac(ldac), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .dac_code(dac_code)
  );

  function automatic logic [DW-1:0] rst_code(input logic mid);
    return mid ? 16'h8000 : 16'h0000;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    rw = 1'b0; bus_din = v; cs_n = 1'b0;
    clocks(4);
    cs_n = 1'b1;
    clocks(4);
    rw = 1'b1;
    m_in = v;
    check("R1 code unchanged by write", dac_code, m_dac);
  endtask

  task automatic do_read();
    rw = 1'b1; cs_n = 1'b0;
    clocks(4);
    check("R4 oe during read", {15'd0, bus_oe}, 16'd1);
    check("R4 readback word", bus_dout, m_in);
    cs_n = 1'b1;
    clocks(4);
    check("R5 oe with select high", {15'd0, bus_oe}, 16'd0);
    check("R10 code unchanged by read", dac_code, m_dac);
  endtask

  task automatic do_load();
    ldac = 1'b1;
    clocks(4);
    m_dac = m_in;
    check("R2 load copies input register", dac_code, m_dac);
    ldac = 1'b0;
    clocks(3);
  endtask

  task automatic do_xpar(input int n);
    ldac = 1'b1;
    clocks(4);
    m_dac = m_in;
    rw = 1'b0; cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      bus_din = 16'($urandom);
      clocks(3);
      m_in = bus_din; m_dac = bus_din;
      check("R3 transparent tracking", dac_code, m_dac);
    end
    cs_n = 1'b1;
    clocks(4);
    rw = 1'b1; ldac = 1'b0;
    clocks(3);
    check("R3 code after transparent burst", dac_code, m_dac);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; rst_mid = 1'b1; cs_n = 1'b1; rw = 1'b1; ldac = 1'b0;
    bus_din = '0;
    clocks(3);
    check("R6 reset state mid", dac_code, 16'h8000);
    check("R5 reset oe", {15'd0, bus_oe}, 16'd0);
    rst_mid = 1'b0;
    clocks(2);
    rst_n = 1'b1;
    clocks(4);
    m_in = 16'h0000; m_dac = 16'h0000;
    check("R6 zero reset held after release", dac_code, 16'h0000);

    do_write(16'hA5C3);
    do_read();
    do_load();

    // R9 latency: visible after the third rising edge, not the second
    do_write(16'h1234);
    ldac = 1'b1;
    clocks(2);
    check("R9 not yet after two edges", dac_code, m_dac);
    clocks(1);
    m_dac = m_in;
    check("R9 visible after third edge", dac_code, m_dac);
    ldac = 1'b0;
    clocks(3);

    // corner codes
    do_write(16'hFFFF); do_load();
    do_write(16'h0001); do_load();
    do_xpar(4);
    do_read();

    // R7/R8: live select during reset, load ignored
    do_write(16'h7E7E);
    #3 rst_n = 1'b0; rst_mid = 1'b1;
    #1 check("R6 immediate mid", dac_code, 16'h8000);
    #2 rst_mid = 1'b0;
    #1 check("R7 follows select to zero", dac_code, 16'h0000);
    #2 rst_mid = 1'b1;
    #1 check("R7 follows select to mid", dac_code, 16'h8000);
    clocks(2);
    ldac = 1'b1;
    clocks(4);
    check("R8 load ignored in reset", dac_code, 16'h8000);
    ldac = 1'b0;
    clocks(2);
    rst_n = 1'b1;
    clocks(4);
    m_in = 16'h8000; m_dac = 16'h8000;
    check("R8 reset value kept after release", dac_code, 16'h8000);
    do_read();

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(3, 0))
        0: do_write(16'($urandom));
        1: do_load();
        2: do_read();
        default: do_xpar(int'($urandom_range(3, 1)));
      endcase
    end
    do_load();
    check("R10 final code", dac_code, m_dac);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule